// File: doc/BRIEF.md
# Debounced Keyboard Matrix Scanner

This block scans a keyboard matrix of `ROWS` rows by 8 columns. It pulls one row line low at a time and holds it for a fixed dwell time. At the end of that dwell it captures all eight column lines as one word. The column lines are active-low: a pressed key pulls its column to 0 while its row is selected. Before use, the column lines pass through a two-stage synchronizer.

For every key, the block keeps two pieces of state:

- the raw level seen on the previous visit to that row;
- a stability counter, which restarts whenever that level changes.

A key is reported only after its new level has stayed the same for `DEBOUNCE_SCANS` further visits to its row. Each report carries a scan code and a press/release flag. The scan code is an 8-bit value computed from the key's row and column.

Reports go into a small queue, and the consumer drains it through a valid/ready handshake. If several keys in one row become reportable on the same visit, they are reported one per cycle, lowest column first. When the queue is full, the scanner waits on the current row. A report is never dropped.

Top module: `keyscan_matrix`

## Requirements
- R1: Exactly one bit of `row_drive_n` is 0 at any time. After reset, row 0 is selected. Rows are visited in ascending order and wrap to row 0 after row `ROWS-1`. Each row stays selected for at least `DWELL_CYCLES` clock cycles.
- R2: `col_n` passes through two register stages. All 8 columns are captured together as one sample word, in the last dwell cycle of the selected row.
- R3: A column sample of 0 means pressed and 1 means released. `out_press` is 1 for a press report and 0 for a release report.
- R4: A key is reported only when its new level has been sampled on `DEBOUNCE_SCANS+1` consecutive visits to its row. Any change restarts the count. A key that returns to its previous debounced level before then produces no report.
- R5: The scan code for row r and column c is `8'h04 + 8*r + c`.
- R6: Keys in one row that become reportable on the same visit are reported one per cycle, in ascending column order.
- R7: When the queue is full, the scanner stays on the current row until space frees up. No report is lost, and nothing is written into a full queue.
- R8: `out_code` and `out_press` stay stable while `out_valid` is 1 and `out_ready` is 0. Reports leave in the order they were produced.
- R9: After reset, every key is taken as released and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_n | input | 8 | Column lines, 0 = key pressed on the selected row |
| out_ready | input | 1 | Consumer can accept a report |
| row_drive_n | output | ROWS | Row select lines, the selected row is 0 |
| out_code | output | 8 | Scan code of the report at the head of the queue |
| out_press | output | 1 | 1 = press, 0 = release |
| out_valid | output | 1 | A report is available |

## Verification
Two actions can fall in the same cycle: the scanner writing a report into the queue and the consumer taking one out. The bench provokes this by pressing all eight keys of one row at once while `out_ready` is held low. This fills the queue and stalls the scanner. `out_ready` is then toggled every cycle, so writes and reads meet both in the full state and in partly filled states. The scoreboard judges the result: all sixteen press and release reports must arrive in ascending column order, with none missing or duplicated. Meanwhile the row lines must stay frozen for as long as the queue is full.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    localparam int COLS = 8;

    typedef logic [COLS-1:0] col_word_t;

    typedef struct packed {
        logic [7:0] code;
        logic       press;
    } key_event_t;

    typedef enum logic {
        PH_DWELL,
        PH_REPORT
    } phase_e;

    // Scan code for a matrix position (R5).
    function automatic logic [7:0] key_code(input int unsigned row, input int unsigned col);
        return 8'(32'h4 + row * 8 + col);
    endfunction

    // Index of the lowest set bit (R6); 0 when none is set.
    function automatic logic [2:0] lowest_col(input col_word_t m);
        logic [2:0] idx;
        idx = '0;
        for (int k = COLS - 1; k >= 0; k--) begin
            if (m[k]) idx = 3'(k);
        end
        return idx;
    endfunction

endpackage

// File: rtl/keyscan_sync.sv
module keyscan_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Reset to all ones: idle (released) column level.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/keyscan_core.sv
module keyscan_core
    import keyscan_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int DWELL  = 16,
    parameter int THRESH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  col_word_t       cols,
    input  logic            full,
    output logic [ROWS-1:0] row_drive_n,
    output logic            push,
    output key_event_t      push_item
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [DW-1:0] DW_LAST  = DW'(DWELL - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(THRESH);

    typedef logic [COLS-1:0][CW-1:0] cnt_row_t;

    phase_e          phase_q;
    logic [RW-1:0]   row_q;
    logic [DW-1:0]   dwell_q;
    col_word_t       pend_q;

    col_word_t       prev_all   [ROWS];
    col_word_t       stable_all [ROWS];
    cnt_row_t        cnt_all    [ROWS];

    col_word_t       prev_cur;
    col_word_t       stable_cur;
    cnt_row_t        cnt_cur;
    cnt_row_t        cnt_nxt;
    col_word_t       fire;
    logic            sample_now;
    logic [2:0]      emit_col;

    assign prev_cur   = prev_all[row_q];
    assign stable_cur = stable_all[row_q];
    assign cnt_cur    = cnt_all[row_q];

    // Per-column stability update for the row being sampled.
    always_comb begin
        sample_now = (phase_q == PH_DWELL) && (dwell_q == DW_LAST);
        for (int c = 0; c < COLS; c++) begin
            if (cols[c] != prev_cur[c])
                cnt_nxt[c] = '0;
            else if (cnt_cur[c] == CNT_TOP)
                cnt_nxt[c] = CNT_TOP;
            else
                cnt_nxt[c] = cnt_cur[c] + CW'(1);
            fire[c] = (cnt_nxt[c] == CNT_TOP) && (cols[c] != stable_cur[c]);
        end
    end

    assign emit_col        = lowest_col(pend_q);
    assign push            = (phase_q == PH_REPORT) && (pend_q != '0) && !full;
    assign push_item.code  = key_code(32'(row_q), 32'(emit_col));
    assign push_item.press = ~prev_cur[emit_col];

    // Row sequencer: dwell, sample, report pending keys, advance.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DWELL;
            row_q   <= '0;
            dwell_q <= '0;
            pend_q  <= '0;
        end else begin
            case (phase_q)
                PH_DWELL: begin
                    if (sample_now) begin
                        pend_q  <= fire;
                        phase_q <= PH_REPORT;
                    end else begin
                        dwell_q <= dwell_q + DW'(1);
                    end
                end
                PH_REPORT: begin
                    if (pend_q == '0) begin
                        phase_q <= PH_DWELL;
                        dwell_q <= '0;
                        row_q   <= (row_q == LAST_ROW) ? '0 : row_q + RW'(1);
                    end else if (push) begin
                        pend_q[emit_col] <= 1'b0;
                    end
                end
                default: phase_q <= PH_DWELL;
            endcase
        end
    end

    // Per-row key state: last raw sample, debounced level, counters.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        col_word_t prev_r;
        col_word_t stable_r;
        cnt_row_t  cnt_r;
        logic      sel;

        assign sel = (row_q == RW'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_r   <= '1;
                stable_r <= '1;
                for (int c = 0; c < COLS; c++) cnt_r[c] <= CNT_TOP;
            end else begin
                if (sample_now && sel) begin
                    prev_r <= cols;
                    cnt_r  <= cnt_nxt;
                end
                if (push && sel) begin
                    stable_r[emit_col] <= prev_r[emit_col];
                end
            end
        end

        assign prev_all[r]    = prev_r;
        assign stable_all[r]  = stable_r;
        assign cnt_all[r]     = cnt_r;
        assign row_drive_n[r] = !sel;
    end
endmodule

// File: rtl/keyscan_fifo.sv
module keyscan_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CAP      = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q;
    logic [AW-1:0]    rd_q;
    logic [AW:0]      cnt_q;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt_q == CAP);
    assign valid   = (cnt_q != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
            if (do_push && !do_pop)      cnt_q <= cnt_q + (AW + 1)'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - (AW + 1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end
endmodule

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
    import keyscan_pkg::*;
#(
    parameter int ROWS           = 4,
    parameter int DWELL_CYCLES   = 16,
    parameter int DEBOUNCE_SCANS = 4,
    parameter int QUEUE_DEPTH    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      col_n,
    input  logic            out_ready,
    output logic [ROWS-1:0] row_drive_n,
    output logic [7:0]      out_code,
    output logic            out_press,
    output logic            out_valid
);
    localparam int ITEM_W = $bits(key_event_t);

    col_word_t  cols_sync;
    logic       core_push;
    key_event_t core_item;
    logic       fifo_full;
    key_event_t head;

    keyscan_sync #(.WIDTH(COLS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (col_n),
        .d_out (cols_sync)
    );

    keyscan_core #(
        .ROWS   (ROWS),
        .DWELL  (DWELL_CYCLES),
        .THRESH (DEBOUNCE_SCANS)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .cols        (cols_sync),
        .full        (fifo_full),
        .row_drive_n (row_drive_n),
        .push        (core_push),
        .push_item   (core_item)
    );

    keyscan_fifo #(
        .WIDTH (ITEM_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (core_push),
        .din   (core_item),
        .full  (fifo_full),
        .pop   (out_ready),
        .dout  (head),
        .valid (out_valid)
    );

    assign out_code  = head.code;
    assign out_press = head.press;
endmodule

// File: rtl/keyscan_checks.sv
module keyscan_checks #(
    parameter int ROWS  = 4,
    parameter int DWELL = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [ROWS-1:0] row_drive_n,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_code,
    input logic            out_press,
    input logic            push,
    input logic            full
);
    localparam int HW = $clog2(DWELL + 1) + 1;
    localparam logic [HW-1:0] HOLD_MIN = HW'(DWELL);

    logic [ROWS-1:0] last_q;
    logic [HW-1:0]   hold_q;
    logic            seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '1;
            hold_q <= '0;
            seen_q <= 1'b0;
        end else begin
            last_q <= row_drive_n;
            seen_q <= 1'b1;
            if (row_drive_n != last_q)  hold_q <= HW'(1);
            else if (hold_q < HOLD_MIN) hold_q <= hold_q + HW'(1);
        end
    end

    // R1: exactly one row selected
    a_r1_one_row: assert property (@(posedge clk) disable iff (rst)
        $countones(~row_drive_n) == 1);

    // R1: a row is left only after the full dwell
    a_r1_dwell_min: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (row_drive_n != last_q)) |-> (hold_q >= HOLD_MIN));

    // R7: the scanner never writes into a full queue
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    // R8: head report held while the consumer stalls
    a_r8_hold_head: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_press)));
endmodule

bind keyscan_matrix keyscan_checks #(
    .ROWS  (ROWS),
    .DWELL (DWELL_CYCLES)
) u_checks (
    .clk         (clk),
    .rst         (rst),
    .row_drive_n (row_drive_n),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_code    (out_code),
    .out_press   (out_press),
    .push        (core_push),
    .full        (fifo_full)
);

// File: tb/keyscan_matrix_test.sv
module keyscan_matrix_test;
    localparam int ROWS   = 4;
    localparam int SETTLE = 700;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      col_n;
    logic            out_ready = 1'b1;
    logic [ROWS-1:0] row_drive_n;
    logic [7:0]      out_code;
    logic            out_press;
    logic            out_valid;

    logic [7:0] keys [ROWS];
    logic [8:0] exp_q [$];
    string      tag_q [$];
    int         n_checks = 0;
    int         n_fail   = 0;
    int         n_out    = 0;

    always #5 clk = ~clk;

    keyscan_matrix uut (
        .clk         (clk),
        .rst         (rst),
        .col_n       (col_n),
        .out_ready   (out_ready),
        .row_drive_n (row_drive_n),
        .out_code    (out_code),
        .out_press   (out_press),
        .out_valid   (out_valid)
    );

    // Matrix model: a pressed key on the selected row pulls its column low.
    always_comb begin
        for (int c = 0; c < 8; c++) begin
            col_n[c] = 1'b1;
            for (int r = 0; r < ROWS; r++)
                if (!row_drive_n[r] && keys[r][c]) col_n[c] = 1'b0;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input int r, input int c);
        return 8'(4 + 8 * r + c);
    endfunction

    task automatic set_key(input int r, input int c, input bit pressed, input string tag);
        keys[r][c] = pressed;
        exp_q.push_back({code_of(r, c), pressed});
        tag_q.push_back(tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: scoreboard pop and compare on each handshake.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            n_out++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected report", {out_code, out_press}, 0);
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_code, out_press} == e, t, {out_code, out_press}, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [ROWS-1:0] rd_snap;
        logic [7:0]      code_snap;
        for (int r = 0; r < ROWS; r++) keys[r] = 8'h00;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        check(out_valid == 1'b0, "R9 valid low after reset", out_valid, 0);
        check(row_drive_n == 4'b1110, "R9 R1 row 0 after reset", row_drive_n, 4'he);
        wait_cyc(9);
        check(row_drive_n == 4'b1110, "R1 row 0 held for dwell", row_drive_n, 4'he);
        wait_cyc(8);
        check(row_drive_n == 4'b1101, "R1 advance to row 1", row_drive_n, 4'hd);

        // Single press/release in two rows
        set_key(0, 0, 1'b1, "R2 R3 R5 press r0c0");
        wait_cyc(SETTLE);
        set_key(0, 0, 1'b0, "R3 release r0c0");
        wait_cyc(SETTLE);
        set_key(2, 5, 1'b1, "R5 press r2c5");
        wait_cyc(SETTLE);
        set_key(2, 5, 1'b0, "R3 R5 release r2c5");
        wait_cyc(SETTLE);

        // Two keys in one row: lowest column first
        keys[1][6] = 1'b1;
        set_key(1, 1, 1'b1, "R6 first press r1c1");
        exp_q.push_back({code_of(1, 6), 1'b1});
        tag_q.push_back("R6 second press r1c6");
        wait_cyc(SETTLE);
        keys[1][6] = 1'b0;
        set_key(1, 1, 1'b0, "R6 first release r1c1");
        exp_q.push_back({code_of(1, 6), 1'b0});
        tag_q.push_back("R6 second release r1c6");
        wait_cyc(SETTLE);

        // Short glitch: must produce no report
        keys[3][2] = 1'b1;
        wait_cyc(40);
        keys[3][2] = 1'b0;
        wait_cyc(SETTLE);
        check(out_valid == 1'b0, "R4 glitch ignored (valid)", out_valid, 0);
        check(n_out == 8, "R4 glitch ignored (report count)", n_out, 8);

        // Full queue: eight keys of row 2 with consumer stalled
        out_ready = 1'b0;
        for (int c = 0; c < 8; c++) set_key(2, c, 1'b1, "R7 R8 burst press row 2");
        wait_cyc(SETTLE);
        rd_snap   = row_drive_n;
        code_snap = out_code;
        check(out_valid == 1'b1, "R7 queue holds reports", out_valid, 1);
        check(rd_snap == 4'b1011, "R7 scan paused on row 2", rd_snap, 4'hb);
        check(code_snap == code_of(2, 0), "R8 head is first report", code_snap, code_of(2, 0));
        wait_cyc(200);
        check(row_drive_n == rd_snap, "R7 row frozen while full", row_drive_n, rd_snap);
        check(out_code == code_snap, "R8 head stable while stalled", out_code, code_snap);
        for (int i = 0; i < 120; i++) begin
            out_ready = ~out_ready;
            wait_cyc(1);
        end
        out_ready = 1'b1;
        wait_cyc(SETTLE);
        for (int c = 0; c < 8; c++) set_key(2, c, 1'b0, "R7 R8 burst release row 2");
        for (int i = 0; i < 60; i++) begin
            out_ready = (i % 3) != 0;
            wait_cyc(5);
        end
        out_ready = 1'b1;
        wait_cyc(SETTLE);

        check(exp_q.size() == 0, "R7 no report lost", exp_q.size(), 0);
        check(n_out == 24, "R8 total reports", n_out, 24);
        finish_run();
    end
endmodule